// File: doc/BRIEF.md
# Twin-Word Carry-Chained Add-Minus-One Unit

This unit takes a 128-bit value built from two 64-bit words, a high word and a low word, and adds a third 64-bit word to it. The third word, the addend, is zero-extended before the add, and the unit then subtracts one. All arithmetic wraps modulo 2^128.

The low 64 bits of that sum become the low result. The high 64 bits are a tentative high result. When the addend is 0 or 1, the tentative high result gets one more increment, modulo 2^64. This increment is applied after any borrow that the minus one has already propagated. The final high result is meant to be written back over the addend register, so the addend is both a source and a destination.

The unit is a single combinational datapath followed by one register stage. A strobe marks each accepted operand set, and the same strobe appears at the output one cycle later. The output register holds its value until the next accepted operand set.

Top module: `twin_carry_adder`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R2: One cycle after an accepted operand set, `low_result` equals (`lo_word` + `addend` - 1) mod 2^64.
- R3: When `addend` is 2 or greater, `addend_new` equals `hi_word` plus the carry out of `lo_word` + (`addend` - 1), modulo 2^64.
- R4: When `addend` is 1, `addend_new` equals `hi_word` + 1 modulo 2^64, and `low_result` equals `lo_word`.
- R5: When `addend` is 0, the minus one borrows out of the low word only if `lo_word` is 0, and the extra increment follows that borrow. So `addend_new` is `hi_word` when `lo_word` is 0, and `hi_word` + 1 otherwise.
- R6: The high result wraps: an all-ones `hi_word` that receives an increment gives `addend_new` = 0.
- R7: While `in_valid` is low, `addend_new` and `low_result` keep their previous values, whatever the operand inputs do.
- R8: While `rst_n` is low, `out_valid`, `addend_new` and `low_result` are zero on the next clock edge and stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set is present and accepted |
| hi_word | input | W | Upper 64 bits of the concatenated operand |
| lo_word | input | W | Lower 64 bits of the concatenated operand |
| addend | input | W | Zero-extended addend; its register is overwritten by `addend_new` |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| addend_new | output | W | Final high result, written back over the addend |
| low_result | output | W | Low half of the sum |

## Verification
The assertions assume that the operand inputs are stable around each rising edge and never carry X while `in_valid` is high. They also assume that reset is held low from time zero for at least one edge, so that `$past` never reads an undefined value. The bench changes every input only on the falling edge and leaves reset asserted for several cycles before the first operand set. When the strobe is low, it also sends deliberately different operand values, so that the hold property is exercised on changing data rather than on idle inputs.

// File: rtl/twin_carry_adder.sv
module twin_carry_adder #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] lo_word,
  input  logic [W-1:0] addend,
  output logic         out_valid,
  output logic [W-1:0] addend_new,
  output logic [W-1:0] low_result
);
  localparam int DW = 2 * W;

  logic [DW-1:0] joined, widened, total;
  logic [W-1:0]  tent_hi, final_hi;
  logic          bump;

  assign joined   = {hi_word, lo_word};
  assign widened  = {{W{1'b0}}, addend};
  assign total    = joined + widened - DW'(1);
  assign tent_hi  = total[DW-1:W];
  assign bump     = (addend[W-1:1] == '0);
  assign final_hi = tent_hi + W'(bump);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      addend_new <= '0;
      low_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addend_new <= final_hi;
        low_result <= total[W-1:0];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> low_result == $past(W'(lo_word + addend - W'(1))));  // R2
  AST_ADDEND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && addend == W'(1) |=> addend_new == W'($past(hi_word) + W'(1)));  // R4
  AST_ZERO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && addend == '0 && lo_word == '0 |=> addend_new == $past(hi_word));  // R5
  AST_ZERO_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && addend == '0 && lo_word != '0 |=> addend_new == W'($past(hi_word) + W'(1)));  // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addend_new) && $stable(low_result));  // R7
endmodule

// File: tb/twin_carry_adder_test.sv
module twin_carry_adder_test;
  localparam int W = 64;
  localparam int N = 9;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] hi_word = '0, lo_word = '0, addend = '0;
  logic out_valid;
  logic [W-1:0] addend_new, low_result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twin_carry_adder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .hi_word(hi_word), .lo_word(lo_word), .addend(addend),
    .out_valid(out_valid), .addend_new(addend_new), .low_result(low_result)
  );

  localparam logic [W-1:0] T_HI [N] = '{64'h10, 64'h10, 64'h7, 64'h7, 64'h7,
    ONES, ONES, 64'h1234, 64'h0};
  localparam logic [W-1:0] T_LO [N] = '{64'h20, ONES, 64'h100, 64'h100, 64'h0,
    64'h5, ONES, 64'h8000_0000_0000_0000, 64'h0};
  localparam logic [W-1:0] T_AD [N] = '{64'h5, 64'h2, 64'h1, 64'h0, 64'h0,
    64'h1, ONES, 64'h8000_0000_0000_0001, 64'h2};
  localparam logic [W-1:0] E_HI [N] = '{64'h10, 64'h11, 64'h8, 64'h8, 64'h7,
    64'h0, 64'h0, 64'h1235, 64'h0};
  localparam logic [W-1:0] E_LO [N] = '{64'h24, 64'h0, 64'h100, 64'hFF, ONES,
    64'h5, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0, 64'h1};
  localparam string TAG [N] = '{"R3", "R3", "R4", "R5", "R5", "R6", "R6", "R3", "R3"};

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [W-1:0] h, input logic [W-1:0] l,
                       input logic [W-1:0] a);
    @(negedge clk);
    in_valid = v; hi_word = h; lo_word = l; addend = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R8 valid", W'(out_valid), '0);
    check("R8 high", addend_new, '0);
    check("R8 low", low_result, '0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      apply(1'b1, T_HI[i], T_LO[i], T_AD[i]);
      check("R1", W'(out_valid), 64'h1);
      check({TAG[i], " high"}, addend_new, E_HI[i]);
      check("R2 low", low_result, E_LO[i]);
    end

    apply(1'b0, 64'hABCD, 64'h1111, 64'h0);
    check("R1 idle", W'(out_valid), '0);
    check("R7 high", addend_new, E_HI[N-1]);
    check("R7 low", low_result, E_LO[N-1]);
    apply(1'b0, ONES, ONES, 64'h1);
    check("R7 high again", addend_new, E_HI[N-1]);
    check("R7 low again", low_result, E_LO[N-1]);

    apply(1'b1, 64'h55, 64'h9, 64'h1);
    check("R4 low", low_result, 64'h9);
    check("R4 high", addend_new, 64'h56);

    @(negedge clk);
    in_valid = 1'b1; hi_word = 64'h99; lo_word = 64'h3; addend = 64'h0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid valid", W'(out_valid), '0);
    check("R8 mid high", addend_new, '0);
    check("R8 mid low", low_result, '0);
    rst_n = 1'b1;
    apply(1'b1, 64'h99, 64'h3, 64'h0);
    check("R5 high", addend_new, 64'h9A);
    check("R5 low", low_result, 64'h2);
    in_valid = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule